// File: doc/BRIEF.md
# Adaptive Valley Index Controller

This block decides at which resonant valley a discontinuous-mode flyback primary switch turns on. It produces a 4-bit count of negative-slope zero crossings that the switch-timing logic waits for before it closes the switch. Waiting for a later valley lowers the switching frequency at light load and at high input voltage. Waiting for an earlier valley allows more power to be delivered.

The block has two inputs. The first is a thermometer-coded level of the peak-current feedback signal, four comparator outputs with bit 0 as the lowest threshold. The second is a single indicator that tells whether the input line voltage is high or low. Both inputs are asynchronous and are synchronized inside the block.

A free-running timer produces a wake tick at a slow, fixed rate. On each tick, the count steps down, holds, steps up or jumps to the maximum, depending on the highest feedback level that is set. The result always stays within limits that depend on the line condition. When the top feedback level is set, the count drops to the line minimum at once and does not wait for a tick.

Top module: `valley_index_ctrl`

## Requirements
- R1: While reset is asserted, and after its release until the first update, `count_o` equals INIT_COUNT (default 1).
- R2: Outside wake ticks and outside the override, `count_o` does not change, whatever happens on `fb_level_i[2:0]` or `line_high_i`.
- R3: While the synchronized `fb_level_i[3]` is 1, `count_o` is forced to the present line minimum. The value appears on the clock edge after the synchronized sample, whether or not a wake tick is present.
- R4: On a wake tick, if bit 3 is 0 and bit 2 is 1 (code 0111), the count decrements by one but never goes below the line minimum.
- R5: On a wake tick, if bits 3 and 2 are 0 and bit 1 is 1 (code 0011), the count holds.
- R6: On a wake tick, if only bit 0 is 1 (code 0001), the count increments by one but never goes above the line maximum.
- R7: On a wake tick, if the feedback code is 0000, the count is set to the line maximum.
- R8: Limits are [LL_MIN, LL_MAX] = [1, 7] when `line_high_i` is 0 and [HL_MIN, HL_MAX] = [3, 9] when it is 1. Every updated value is clamped to the limits of the present line, including right after the line indicator changes.
- R9: Wake ticks occur once every WAKE_CYCLES clock cycles. The first tick updates the count on the WAKE_CYCLES-th rising edge after reset is released.
- R10: Both inputs pass through a two-flop synchronizer. A change that is stable before a rising edge affects `count_o` on the third rising edge, counting that edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fb_level_i | input | 4 | Thermometer-coded feedback level, bit 0 lowest |
| line_high_i | input | 1 | 1 = high line, 0 = low line |
| count_o | output | 4 | Number of negative-slope zero crossings to wait for |

## Verification
The assertions check three things on every cycle: the count stays inside the union of both line ranges, it stays stable between ticks when there is no override, and it follows the override, decrement and empty-code rules one cycle after the synchronized cause. The bench's reference model covers what depends on history: tick spacing from reset, the two-cycle synchronizer latency, saturation at each limit, and clamping after a line change. These only show up across long scenarios, which step the count up, down, hold it, empty it, toggle the line and fire the override.

// File: rtl/valley_pkg.sv
package valley_pkg;
  typedef enum logic [1:0] {
    ACT_DOWN = 2'd0,
    ACT_HOLD = 2'd1,
    ACT_UP   = 2'd2,
    ACT_MAX  = 2'd3
  } wake_act_e;

  // priority from the top threshold down; bit 3 is handled as the override
  function automatic wake_act_e decode_act(input logic [3:0] lvl);
    if (lvl[2])      return ACT_DOWN;
    else if (lvl[1]) return ACT_HOLD;
    else if (lvl[0]) return ACT_UP;
    else             return ACT_MAX;
  endfunction
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/vic_wake_timer.sv
module vic_wake_timer #(
  parameter int WAKE_CYCLES = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vic_next_count.sv
module vic_next_count
  import valley_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int LL_MIN = 1,
  parameter int LL_MAX = 7,
  parameter int HL_MIN = 3,
  parameter int HL_MAX = 9
) (
  input  logic [CNT_W-1:0] cur_i,
  input  logic [3:0]       lvl_i,
  input  logic             line_high_i,
  input  logic             tick_i,
  output logic             load_o,
  output logic [CNT_W-1:0] nxt_o
);
  localparam logic [CNT_W-1:0] LL_LO = CNT_W'(LL_MIN);
  localparam logic [CNT_W-1:0] LL_HI = CNT_W'(LL_MAX);
  localparam logic [CNT_W-1:0] HL_LO = CNT_W'(HL_MIN);
  localparam logic [CNT_W-1:0] HL_HI = CNT_W'(HL_MAX);

  logic [CNT_W-1:0] lo, hi, raw;
  wake_act_e        act;

  assign lo  = line_high_i ? HL_LO : LL_LO;
  assign hi  = line_high_i ? HL_HI : LL_HI;
  assign act = decode_act(lvl_i);

  always_comb begin
    unique case (act)
      ACT_DOWN: raw = (cur_i > lo) ? cur_i - 1'b1 : lo;
      ACT_HOLD: raw = cur_i;
      ACT_UP:   raw = (cur_i < hi) ? cur_i + 1'b1 : hi;
      default:  raw = hi;
    endcase
    if (lvl_i[3])       nxt_o = lo;
    else if (raw < lo)  nxt_o = lo;
    else if (raw > hi)  nxt_o = hi;
    else                nxt_o = raw;
  end

  assign load_o = lvl_i[3] | tick_i;
endmodule

// File: rtl/valley_index_ctrl.sv
module valley_index_ctrl #(
  parameter int CNT_W       = 4,
  parameter int INIT_COUNT  = 1,
  parameter int LL_MIN      = 1,
  parameter int LL_MAX      = 7,
  parameter int HL_MIN      = 3,
  parameter int HL_MAX      = 9,
  parameter int WAKE_CYCLES = 2_500_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       fb_level_i,
  input  logic             line_high_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] sync_q;
  logic [3:0]        fb_sync;
  logic              line_sync;
  logic              wake_tick;
  logic              load;
  logic [CNT_W-1:0]  nxt, count_q;

  vic_sync #(.W(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({line_high_i, fb_level_i}),
    .q_o   (sync_q)
  );

  assign fb_sync   = sync_q[3:0];
  assign line_sync = sync_q[4];

  vic_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(wake_tick)
  );

  vic_next_count #(
    .CNT_W (CNT_W),
    .LL_MIN(LL_MIN),
    .LL_MAX(LL_MAX),
    .HL_MIN(HL_MIN),
    .HL_MAX(HL_MAX)
  ) u_next (
    .cur_i      (count_q),
    .lvl_i      (fb_sync),
    .line_high_i(line_sync),
    .tick_i     (wake_tick),
    .load_o     (load),
    .nxt_o      (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   count_q <= CNT_W'(INIT_COUNT);
    else if (load) count_q <= nxt;
  end

  assign count_o = count_q;
endmodule

// File: rtl/valley_index_ctrl_chk.sv
module valley_index_ctrl_chk #(
  parameter int CNT_W  = 4,
  parameter int LL_MIN = 1,
  parameter int LL_MAX = 7,
  parameter int HL_MIN = 3,
  parameter int HL_MAX = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [3:0]       fb_s_i,
  input logic             line_s_i,
  input logic [CNT_W-1:0] count_i
);
  localparam int ABS_MIN = (LL_MIN < HL_MIN) ? LL_MIN : HL_MIN;
  localparam int ABS_MAX = (LL_MAX > HL_MAX) ? LL_MAX : HL_MAX;

  AST_COUNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_i) >= ABS_MIN) && (int'(count_i) <= ABS_MAX)); // R8

  AST_STABLE_BETWEEN_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !fb_s_i[3]) |=> $stable(count_i)); // R2

  AST_OVERRIDE_TO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_s_i[3] |=> (int'(count_i) == ($past(line_s_i) ? HL_MIN : LL_MIN))); // R3

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !fb_s_i[3] && fb_s_i[2]) |=>
      ((count_i < $past(count_i)) || (int'(count_i) == ($past(line_s_i) ? HL_MIN : LL_MIN)))); // R4

  AST_EMPTY_TO_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (fb_s_i == 4'b0000)) |=> (int'(count_i) == ($past(line_s_i) ? HL_MAX : LL_MAX))); // R7

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i); // R9
endmodule

bind valley_index_ctrl valley_index_ctrl_chk #(
  .CNT_W (CNT_W),
  .LL_MIN(LL_MIN),
  .LL_MAX(LL_MAX),
  .HL_MIN(HL_MIN),
  .HL_MAX(HL_MAX)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (wake_tick),
  .fb_s_i  (fb_sync),
  .line_s_i(line_sync),
  .count_i (count_o)
);

// File: tb/valley_index_ctrl_test.sv
`timescale 1ns/1ps
module valley_index_ctrl_test;
  localparam int W  = 16;
  localparam int LLN = 1, LLX = 7, HLN = 3, HLX = 9;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] fb = 4'b0000;
  logic       line = 1'b0;
  logic [3:0] count;

  int vectors = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference state
  int ref_count = 1, tmr = 0;
  int s1_fb = 0, s2_fb = 0, s1_ln = 0, s2_ln = 0;

  always #2 clk = ~clk;

  valley_index_ctrl #(
    .CNT_W(4), .INIT_COUNT(1), .LL_MIN(LLN), .LL_MAX(LLX),
    .HL_MIN(HLN), .HL_MAX(HLX), .WAKE_CYCLES(W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fb_level_i(fb), .line_high_i(line), .count_o(count)
  );

  always @(posedge clk) begin
    if (!rst_ni) begin
      ref_count = 1; tmr = 0; s1_fb = 0; s2_fb = 0; s1_ln = 0; s2_ln = 0;
    end else begin
      int lo, hi, nc;
      bit tick;
      lo = s2_ln ? HLN : LLN;
      hi = s2_ln ? HLX : LLX;
      tick = (tmr == W - 1);
      nc = ref_count;
      if (s2_fb[3]) nc = lo;
      else if (tick) begin
        if (s2_fb[2])      nc = (ref_count > lo) ? ref_count - 1 : lo;
        else if (s2_fb[1]) nc = ref_count;
        else if (s2_fb[0]) nc = (ref_count < hi) ? ref_count + 1 : hi;
        else               nc = hi;
        if (nc < lo) nc = lo;
        if (nc > hi) nc = hi;
      end
      ref_count = nc;
      tmr = tick ? 0 : tmr + 1;
      s2_fb = s1_fb; s1_fb = int'(fb);
      s2_ln = s1_ln; s1_ln = int'(line);
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    vectors++;
    if (int'(count) != ref_count) begin
      fails++;
      $display("FAIL %s cycle %0d: count_o=%0d expected=%0d", cur_req, cyc, count, ref_count);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic set_lvl(input int n);
    fb = 4'((1 << n) - 1);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    run(4);
    rst_ni = 1'b1;
    set_lvl(2);
    run(W - 1);                       // R1 held until first tick
    cur_req = "R9 R10";
    run(W * 2);
    cur_req = "R6 R8";
    set_lvl(1); run(W * 10);          // climb to 7 and saturate
    cur_req = "R2";
    for (int i = 0; i < W * 6; i++) begin  // churn bits 2:0 between wakes
      set_lvl($urandom_range(0, 3));
      @(negedge clk);
    end
    cur_req = "R4 R8";
    set_lvl(3); run(W * 10);          // descend to 1 and saturate
    cur_req = "R5";
    set_lvl(2); run(W * 3);
    cur_req = "R8";
    line = 1'b1; run(W * 3);          // hold clamps 1 up to 3
    cur_req = "R7";
    set_lvl(0); run(W * 2);           // jump to 9
    cur_req = "R8";
    set_lvl(2); line = 1'b0; run(W * 3); // clamp 9 down to 7
    cur_req = "R3 R10";
    run(W / 2); set_lvl(4); run(5);
    set_lvl(2); run(W * 2);
    line = 1'b1; set_lvl(0); run(W * 2);
    set_lvl(4); run(3); set_lvl(1); run(W * 2);
    cur_req = "R2 R3 R4 R5 R6 R7 R8";
    for (int i = 0; i < W * 300; i++) begin
      set_lvl($urandom_range(0, 4));
      if ($urandom_range(0, 40) == 0) line = ~line;
      run($urandom_range(1, W));
    end
    summary();
    $finish;
  end
endmodule